// File: doc/BRIEF.md
# Put-Priority Queue with Error Pulse

This block is a synchronous first-in first-out store of parameterised depth and data width. Each clock cycle it carries out at most one request. A write strobe (`put`) appends the value on `din`. A read strobe (`get`) removes the oldest element. When both strobes are high in the same cycle, the write wins and nothing is removed. The oldest stored element is always visible on `head`, and `count` reports how many elements are held.

The block gives no full or empty flags to hold callers back. A request that cannot be served, either a write while full or a lone read while empty, leaves the contents and the count untouched. It raises `err` for exactly one cycle, and the queue carries on normally afterwards. Storage is a circular buffer whose read and write positions wrap modulo the depth, so any depth works, including depths that are not a power of two. Reset is synchronous and active-high. While `count` is 0 the value on `head` carries no meaning.

Top module: `pp_fifo`

## Requirements
- R1: One cycle after `rst` is sampled high, `count` is 0 and `err` is 0.
- R2: A write while `count` equals DEPTH sets `err` to 1 on the next cycle, and neither `count` nor `head` changes.
- R3: A write while `count` is below DEPTH raises `count` by one on the next cycle, with `err` at 0.
- R4: A write into an empty queue makes `head` equal, on the next cycle, the `din` value that was written.
- R5: A write while the queue holds between 1 and DEPTH-1 elements leaves `head` unchanged on the next cycle.
- R6: A read with `put` low while `count` is 0 sets `err` to 1 on the next cycle, and `count` stays 0.
- R7: A read with `put` low while `count` is nonzero lowers `count` by one on the next cycle, with `err` at 0. `head` then shows the next-oldest element.
- R8: With both strobes low, `err` is 0 on the next cycle, and `count` and `head` hold their values.
- R9: With both strobes high, only the write takes effect: no element is removed, and `count` either rises by one or, when full, stays put with `err` raised.
- R10: `err` is a one-cycle pulse per rejected request. `count` and `head` hold their values in any cycle where `err` rises. Elements leave in exactly the order they were written, across any number of pointer wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| put | input | 1 | Write request, has priority over `get` |
| din | input | WIDTH | Data appended on a write |
| get | input | 1 | Read request, removes the oldest element |
| head | output | WIDTH | Oldest stored element, meaningless when empty |
| count | output | $clog2(DEPTH+1) | Number of stored elements, 0 to DEPTH |
| err | output | 1 | One-cycle pulse after a rejected request |

## Verification
The bench builds the queue with DEPTH = 3 and WIDTH = 8. A depth that is not a power of two exercises the explicit modulo wrap of both buffer positions, which a power-of-two depth would hide behind natural binary rollover. A shallow depth also lets random traffic reach the full and empty boundaries often. Directed sequences cover overflow, underflow, a combined request on a full queue and a combined request on an empty queue. A long random run then mixes all four request kinds across many wraps.

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             put,
  input  logic [WIDTH-1:0] din,
  input  logic             get,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             err
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  wire full  = (count == CW'(DEPTH));
  wire empty = (count == '0);
  wire do_wr = put && !full;
  wire do_rd = !put && get && !empty;
  wire bad   = (put && full) || (!put && get && empty);

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      err    <= 1'b0;
    end else begin
      err <= bad;
      if (do_wr) begin
        wr_ptr <= step_ptr(wr_ptr);
        count  <= count + 1'b1;
      end else if (do_rd) begin
        rd_ptr <= step_ptr(rd_ptr);
        count  <= count - 1'b1;
      end
    end
  end

endmodule

module pp_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             put,
  input logic [WIDTH-1:0] din,
  input logic             get,
  input logic [WIDTH-1:0] head,
  input logic [CW-1:0]    count,
  input logic             err
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0 && !err));

  a_r2_overflow: assert property (@(posedge clk) disable iff (rst)
    (put && count == CW'(DEPTH)) |=> (err && $stable(count) && $stable(head)));

  a_r3_put_inc: assert property (@(posedge clk) disable iff (rst)
    (put && count < CW'(DEPTH)) |=> (!err && count == $past(count) + 1'b1));

  a_r4_put_empty_head: assert property (@(posedge clk) disable iff (rst)
    (put && count == '0) |=> (head == $past(din)));

  a_r5_put_head_hold: assert property (@(posedge clk) disable iff (rst)
    (put && count != '0 && count < CW'(DEPTH)) |=> $stable(head));

  a_r6_underflow: assert property (@(posedge clk) disable iff (rst)
    (!put && get && count == '0) |=> (err && count == '0));

  a_r7_pop_dec: assert property (@(posedge clk) disable iff (rst)
    (!put && get && count != '0) |=> (!err && count == $past(count) - 1'b1));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!put && !get && count != '0) |=> (!err && $stable(count) && $stable(head)));

  a_r9_put_wins: assert property (@(posedge clk) disable iff (rst)
    (put && get && count != '0 && count < CW'(DEPTH)) |=> $stable(head));

  a_r10_err_freeze: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ($stable(count) && (count == '0 || $stable(head))));

  a_r10_count_range: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

endmodule

bind pp_fifo pp_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .put(put), .din(din), .get(get),
  .head(head), .count(count), .err(err)
);

// File: tb/pp_fifo_tb.sv
`timescale 1ns/1ps
module pp_fifo_tb;
  localparam int D  = 3;
  localparam int W  = 8;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic put = 1'b0, get = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] head;
  logic [CW-1:0] count;
  logic err;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] q[$];
  logic m_err = 1'b0;

  always #2.5 clk = ~clk;

  pp_fifo #(.DEPTH(D), .WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .put(put), .din(din), .get(get),
    .head(head), .count(count), .err(err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "count", int'(count), q.size());
    chk(tag, "err", int'(err), int'(m_err));
    if (q.size() != 0) chk(tag, "head", int'(head), int'(q[0]));
  endtask

  task automatic step(input logic p, input logic g, input logic [W-1:0] d);
    string tag;
    if (p) begin
      if (q.size() == D) tag = "R2";
      else if (q.size() == 0) tag = "R3/R4";
      else tag = "R3/R5";
      if (g) tag = {tag, "/R9"};
    end else if (g) tag = (q.size() == 0) ? "R6" : "R7";
    else tag = "R8";
    put = p; get = g; din = d;
    @(posedge clk);
    if (p) begin
      if (q.size() == D) m_err = 1'b1;
      else begin q.push_back(d); m_err = 1'b0; end
    end else if (g) begin
      if (q.size() == 0) m_err = 1'b1;
      else begin void'(q.pop_front()); m_err = 1'b0; end
    end else m_err = 1'b0;
    @(negedge clk);
    compare({tag, "/R10"});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "count", int'(count), 0);
    chk("R1", "err", int'(err), 0);

    step(0, 1, 8'h00);              // R6 underflow
    step(0, 0, 8'h00);              // R8 err drops
    step(1, 0, 8'hA1);              // R4
    step(1, 1, 8'hB2);              // R9 put wins
    step(1, 0, 8'hC3);              // full
    step(1, 0, 8'hD4);              // R2 overflow
    step(1, 1, 8'hE5);              // R2 + R9, no pop
    step(0, 0, 8'h00);
    step(0, 1, 8'h00);              // R7
    step(0, 1, 8'h00);
    step(0, 1, 8'h00);
    step(0, 1, 8'h00);              // R6
    step(1, 1, 8'h5A);              // R9 on empty
    step(0, 1, 8'h00);

    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 45, (r >= 30 && r < 85), 8'($urandom));
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q.delete(); m_err = 1'b0;
    chk("R1", "count", int'(count), 0);
    chk("R1", "err", int'(err), 0);
    step(1, 0, 8'h77);
    step(0, 1, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule